// File: doc/BRIEF.md
# Transmit Sample Feeder with Underrun Ramp-Down

This block sits between a transmit sample FIFO and a DAC. Each FIFO word is a 16-bit signed sample. The words are written into a bank of eight sample registers, which form up to four I/Q channel pairs. A word is stored only while the fill position is below a configurable slot limit.

A FIFO underrun needs special handling. If the bank simply kept the last sample, the DAC would go on producing a carrier. Instead, the block captures the values it holds at the moment of underrun and scales every output down to exactly zero over eight clocks. It then parks at zero and raises an idle flag. When data returns during a ramp, the ramp is abandoned, the fill position restarts at slot 0, and loading resumes on the next clock.

Top module: `tsf_feeder`

## Requirements
- R1: While `rst` is high at a clock edge, all eight outputs become zero, the fill position becomes 0, `ramp_idle` becomes 1, and `fifo_rd` stays low until data is present after reset.
- R2: The k-th word read after the fill position was cleared goes to slot k. Slot 2c holds I of channel c and slot 2c+1 holds Q of channel c. Slot i occupies bits [16i+15:16i] of `dac_samples`. The bank holds the head word while `fifo_empty` is low and `fifo_rd` is high.
- R3: `fifo_rd` is high only when all of these hold: the block is in its loading state, `fifo_empty` is low, and the fill position is below the limit. The limit is min(`slot_count`, 8).
- R4: Whenever `fifo_empty` is high at a clock edge, the fill position returns to 0, so the first word after an underrun lands in slot 0.
- R5: When `fifo_empty` is high in the loading state, the block captures each output value h. Over the next eight clocks in which the FIFO stays empty, the outputs are floor(h*k/8) for k = 7, 6, ..., 0, so they are exactly zero on the eighth clock.
- R6: During a ramp, no output has the opposite sign of its captured value, and no output has a larger magnitude than it.
- R7: If `fifo_empty` is low during a ramp clock, the outputs keep their current values on that edge and the block returns to loading with the fill position at 0. `fifo_rd` does not assert in that first clock.
- R8: `ramp_idle` rises on the same edge that the ramp writes zero, and stays high with all outputs at zero while the FIFO remains empty. It falls on the first edge where `fifo_empty` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_data | input | 16 | Head word of the FIFO (signed sample) |
| fifo_empty | input | 1 | FIFO has no word to offer |
| slot_count | input | 4 | Number of slots to fill, clamped to 8 |
| fifo_rd | output | 1 | Consume the head word this clock |
| dac_samples | output | 128 | Eight registered signed samples, slot i at bits 16i+15:16i |
| ramp_idle | output | 1 | Outputs parked at zero after a finished ramp |

## Verification
A wrong fill position shows up on the very next stored word, as a sample in the wrong slot of `dac_samples`. It can also show up as `fifo_rd` asserting past the limit in the same cycle. A wrong step count or a bad capture register shows up within the eight-clock ramp: a step deviates from floor(h*k/8), or the bank arrives at zero early, late or never, with `ramp_idle` out of step with it. The bench compares every output on every clock against a reference model, so any such fault is reported in the cycle it first appears.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    localparam int TSF_SAMPLE_W = 16;
    localparam int TSF_SLOTS    = 8;
    localparam int TSF_STEP_W   = 3;   // ramp length is 2**TSF_STEP_W clocks

    typedef enum logic [1:0] {
        TSF_LOAD = 2'd0,
        TSF_RAMP = 2'd1,
        TSF_IDLE = 2'd2
    } tsf_mode_e;

    typedef struct packed {
        logic                  start;    // capture bank and apply first step
        logic                  scale_en; // apply a later step to captured values
        logic [TSF_STEP_W-1:0] k;        // multiplier numerator, divided by 2**STEP_W
    } tsf_ramp_cmd_t;

endpackage

// File: rtl/tsf_ramp_ctrl.sv
module tsf_ramp_ctrl
    import tsf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_empty,
    output tsf_mode_e     mode_q,
    output tsf_ramp_cmd_t cmd
);

    logic [TSF_STEP_W-1:0] step_q;

    always_comb begin
        cmd = '0;
        if (mode_q == TSF_LOAD && fifo_empty) begin
            cmd.start = 1'b1;
            cmd.k     = '1;
        end else if (mode_q == TSF_RAMP && fifo_empty) begin
            cmd.scale_en = 1'b1;
            cmd.k        = ~step_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= TSF_IDLE;
            step_q <= '0;
        end else begin
            case (mode_q)
                TSF_LOAD: begin
                    if (fifo_empty) begin
                        mode_q <= TSF_RAMP;
                        step_q <= TSF_STEP_W'(1);
                    end
                end
                TSF_RAMP: begin
                    if (!fifo_empty) begin
                        mode_q <= TSF_LOAD;
                    end else begin
                        step_q <= step_q + TSF_STEP_W'(1);
                        if (step_q == '1) mode_q <= TSF_IDLE;
                    end
                end
                default: begin
                    if (!fifo_empty) mode_q <= TSF_LOAD;
                end
            endcase
        end
    end

endmodule

// File: rtl/tsf_slot_ctrl.sv
module tsf_slot_ctrl #(
    parameter  int NSLOT = tsf_pkg::TSF_SLOTS,
    localparam int CW    = $clog2(NSLOT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_mode,
    input  logic          fifo_empty,
    input  logic [CW-1:0] slot_count,
    output logic          rd,
    output logic [CW-1:0] slot_q
);

    logic [CW-1:0] limit;

    always_comb begin
        limit = (slot_count > CW'(NSLOT)) ? CW'(NSLOT) : slot_count;
        rd    = load_mode && !fifo_empty && (slot_q < limit);
    end

    always_ff @(posedge clk) begin
        if (rst || fifo_empty || !load_mode) slot_q <= '0;
        else if (rd)                          slot_q <= slot_q + CW'(1);
    end

endmodule

// File: rtl/tsf_sample_bank.sv
module tsf_sample_bank
    import tsf_pkg::*;
#(
    parameter  int W     = TSF_SAMPLE_W,
    parameter  int NSLOT = TSF_SLOTS,
    localparam int CW    = $clog2(NSLOT + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [CW-1:0]      wr_slot,
    input  logic [W-1:0]       wr_data,
    input  tsf_ramp_cmd_t      cmd,
    output logic [NSLOT*W-1:0] samples
);

    // floor(x * k / 2**STEP_W) by shift-and-add at full precision
    function automatic logic [W-1:0] scale(input logic [W-1:0] x,
                                           input logic [TSF_STEP_W-1:0] k);
        logic signed [W+TSF_STEP_W-1:0] xe;
        logic signed [W+TSF_STEP_W-1:0] acc;
        logic signed [W+TSF_STEP_W-1:0] res;
        xe  = {{TSF_STEP_W{x[W-1]}}, x};
        acc = '0;
        for (int b = 0; b < TSF_STEP_W; b++) begin
            if (k[b]) acc = acc + (xe <<< b);
        end
        res = acc >>> TSF_STEP_W;
        return res[W-1:0];
    endfunction

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic [W-1:0] smp_q;
        logic [W-1:0] hold_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                smp_q  <= '0;
                hold_q <= '0;
            end else if (cmd.start) begin
                hold_q <= smp_q;
                smp_q  <= scale(smp_q, cmd.k);
            end else if (cmd.scale_en) begin
                smp_q  <= scale(hold_q, cmd.k);
            end else if (wr_en && wr_slot == CW'(i)) begin
                smp_q  <= wr_data;
            end
        end

        assign samples[i*W +: W] = smp_q;
    end

endmodule

// File: rtl/tsf_feeder.sv
module tsf_feeder
    import tsf_pkg::*;
#(
    parameter  int W     = TSF_SAMPLE_W,
    parameter  int NSLOT = TSF_SLOTS,
    localparam int CW    = $clog2(NSLOT + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [W-1:0]       fifo_data,
    input  logic               fifo_empty,
    input  logic [CW-1:0]      slot_count,
    output logic               fifo_rd,
    output logic [NSLOT*W-1:0] dac_samples,
    output logic               ramp_idle
);

    tsf_mode_e     mode_q;
    tsf_ramp_cmd_t cmd;
    logic [CW-1:0] slot_q;

    tsf_ramp_ctrl u_ramp (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .mode_q     (mode_q),
        .cmd        (cmd)
    );

    tsf_slot_ctrl #(.NSLOT(NSLOT)) u_slot (
        .clk        (clk),
        .rst        (rst),
        .load_mode  (mode_q == TSF_LOAD),
        .fifo_empty (fifo_empty),
        .slot_count (slot_count),
        .rd         (fifo_rd),
        .slot_q     (slot_q)
    );

    tsf_sample_bank #(.W(W), .NSLOT(NSLOT)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (fifo_rd),
        .wr_slot (slot_q),
        .wr_data (fifo_data),
        .cmd     (cmd),
        .samples (dac_samples)
    );

    assign ramp_idle = (mode_q == TSF_IDLE);

endmodule

// File: rtl/tsf_feeder_chk.sv
module tsf_feeder_chk
    import tsf_pkg::*;
#(
    parameter int W     = TSF_SAMPLE_W,
    parameter int NSLOT = TSF_SLOTS
) (
    input logic               clk,
    input logic               rst,
    input logic               fifo_empty,
    input logic               fifo_rd,
    input logic               ramp_idle,
    input logic [NSLOT*W-1:0] dac_samples,
    input tsf_mode_e          mode_q
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (dac_samples == '0 && ramp_idle && !fifo_rd));

    assert_read_gate_R3: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (!fifo_empty && mode_q == TSF_LOAD));

    assert_ramp_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == TSF_LOAD && fifo_empty) |=> (mode_q == TSF_RAMP));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ramp_idle) |-> (dac_samples == '0));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ramp_idle && fifo_empty) |=> (ramp_idle && dac_samples == '0));

    assert_abandon_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == TSF_RAMP && !fifo_empty) |=>
            (mode_q == TSF_LOAD && $stable(dac_samples) && !ramp_idle));

endmodule

bind tsf_feeder tsf_feeder_chk #(.W(W), .NSLOT(NSLOT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fifo_empty  (fifo_empty),
    .fifo_rd     (fifo_rd),
    .ramp_idle   (ramp_idle),
    .dac_samples (dac_samples),
    .mode_q      (mode_q)
);

// File: tb/tb_tsf_feeder.sv
`timescale 1ns/1ps
module tb_tsf_feeder;

    localparam int W = 16;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic [W-1:0]   fifo_data;
    logic           fifo_empty;
    logic [3:0]     slot_count;
    logic           fifo_rd;
    logic [N*W-1:0] dac_samples;
    logic           ramp_idle;

    always #4 clk = ~clk;   // 125 MHz

    tsf_feeder dut (
        .clk(clk), .rst(rst), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .slot_count(slot_count), .fifo_rd(fifo_rd),
        .dac_samples(dac_samples), .ramp_idle(ramp_idle)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // reference model: 0 loading, 1 ramping, 2 idle
    logic signed [W-1:0] m_out  [N];
    logic signed [W-1:0] m_hold [N];
    int m_mode, m_step, m_slot;
    logic [W-1:0] q[$];

    function automatic logic signed [W-1:0] ref_scale(logic signed [W-1:0] x, int k);
        int p;
        p = int'(x) * k;
        return W'(p >>> 3);
    endfunction

    function automatic int ref_limit(logic [3:0] c);
        return (int'(c) > N) ? N : int'(c);
    endfunction

    function automatic logic [N*W-1:0] ref_vec();
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = m_out[i];
        return v;
    endfunction

    task automatic check(string tag, bit ok, logic [N*W:0] act, logic [N*W:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin m_out[i] = '0; m_hold[i] = '0; end
        m_mode = 2; m_step = 0; m_slot = 0;
    endtask

    // one clock: check outputs, drive inputs, check read, advance model
    task automatic tick(bit force_empty);
        bit e, rd_exp, sign_ok;
        string tag;
        tag = (m_mode == 0) ? "R2 R4" : (m_mode == 1) ? "R5" : "R8";
        check(tag, {ramp_idle, dac_samples} == {(m_mode == 2), ref_vec()},
              {ramp_idle, dac_samples}, {(m_mode == 2), ref_vec()});
        if (m_mode != 0) begin
            sign_ok = 1;
            for (int i = 0; i < N; i++) begin
                logic signed [W-1:0] a;
                a = dac_samples[i*W +: W];
                if (a != 0 && ((a < 0) != (m_hold[i] < 0))) sign_ok = 0;
                if ((a < 0 ? -int'(a) : int'(a)) > (m_hold[i] < 0 ? -int'(m_hold[i]) : int'(m_hold[i])))
                    sign_ok = 0;
            end
            check("R6", sign_ok, dac_samples, ref_vec());
        end
        e = force_empty || (q.size() == 0);
        fifo_empty = e;
        fifo_data  = e ? W'($urandom) : q[0];
        #1;
        rd_exp = (m_mode == 0) && !e && (m_slot < ref_limit(slot_count));
        check((m_mode == 0) ? "R3" : "R7", fifo_rd == rd_exp, fifo_rd, rd_exp);
        case (m_mode)
            0: if (e) begin
                   for (int i = 0; i < N; i++) begin
                       m_hold[i] = m_out[i];
                       m_out[i]  = ref_scale(m_out[i], 7);
                   end
                   m_mode = 1; m_step = 1; m_slot = 0;
               end else if (rd_exp) begin
                   m_out[m_slot] = q[0];
                   m_slot++;
               end
            1: if (!e) begin
                   m_mode = 0; m_slot = 0;
               end else begin
                   for (int i = 0; i < N; i++) m_out[i] = ref_scale(m_hold[i], 7 - m_step);
                   if (m_step == 7) m_mode = 2;
                   m_step = (m_step + 1) % 8;
               end
            default: if (!e) m_mode = 0;
        endcase
        if (rd_exp) void'(q.pop_front());
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        rst = 1; fifo_empty = 1; fifo_data = '0; slot_count = 4'd8;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {ramp_idle, dac_samples} == {1'b1, {(N*W){1'b0}}},
              {ramp_idle, dac_samples}, {1'b1, {(N*W){1'b0}}});
        rst = 0;

        // full-scale and sign corner values, then natural underrun and full ramp
        foreach (q[i]) ;
        q.push_back(16'h7FFF); q.push_back(16'h8000); q.push_back(16'hFFFF); q.push_back(16'h0001);
        q.push_back(16'h1234); q.push_back(16'hEDCB); q.push_back(16'h0008); q.push_back(16'hFFF8);
        repeat (22) tick(0);

        // abandon a ramp mid-way (R7), then reload four slots
        for (int i = 0; i < 8; i++) q.push_back(W'(16'h4000 - i * 16'h0999));
        repeat (10) tick(0);
        repeat (3) tick(1);
        slot_count = 4'd4;
        for (int i = 0; i < 4; i++) q.push_back(W'(16'hC000 + i));
        repeat (8) tick(0);
        repeat (12) tick(1);

        // zero slots: no read while data waits
        slot_count = 4'd0;
        for (int i = 0; i < 3; i++) q.push_back(W'(i + 5));
        repeat (6) tick(0);
        repeat (2) tick(1);

        // count above eight clamps to eight
        slot_count = 4'd13;
        for (int i = 0; i < 10; i++) q.push_back(W'($urandom));
        repeat (16) tick(0);
        repeat (12) tick(1);

        // constrained random traffic
        for (int c = 0; c < 4000; c++) begin
            int pct;
            if (c % 300 == 0) slot_count = 4'($urandom_range(0, 15));
            case ((c / 200) % 4)
                0: pct = 100; 1: pct = 30; 2: pct = 90; default: pct = 0;
            endcase
            if (q.size() < 32 && $urandom_range(0, 99) < pct) q.push_back(W'($urandom));
            tick($urandom_range(0, 49) == 0);
        end

        done = 1;
        summary();
    end

endmodule